// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block merges the interrupt events of a two-channel serial controller into a single request line. Every channel contributes three event groups, and a DMA group and a general-purpose input group (split into a low and a high half) add three more. That makes nine status registers, each paired with a mask register. Event sources arrive as single-cycle pulse vectors, one vector per status register.

Software uses one line for every cause. It reads a read-only global summary to see which status registers hold unmasked pending bits, and then reads those status registers. Each of those reads clears the bits it returns. A mode register holds four controls:

- a global block for the whole line;
- a visibility switch that records masked events without letting them raise the line;
- the drive style of the pin;
- the polarity of the pin.

The block has no state machine. The datapath is nine identical status/mask slices, a combinational register decoder and a pin driver.

Top module: `irq_hub`

Register map (5-bit address):

| Address | Contents |
|---|---|
| 0 to 5 | Channel status registers: channel A groups 0 to 2, then channel B groups 0 to 2 |
| 6 | DMA status register |
| 7 | General-purpose input status, low half |
| 8 | General-purpose input status, high half |
| 16+g | Mask register for status register g |
| 12 | Mode register |
| 13 | Global status, bits 7:0 |
| 14 | Global status, bits 15:8 |

All other addresses read 0.

Mode register fields:

| Bit | Name | Meaning |
|---|---|---|
| 0 | global block | 1 blocks the line; reset value 1 |
| 1 | visibility | 1 records masked events in the status registers |
| 2 | drive | 0 = push-pull, 1 = open-drain |
| 3 | polarity | 0 = active-low, 1 = active-high |

## Requirements
- R1: After reset every status register reads 0, every mask register reads all ones, and the mode register reads 0x01. The line is inactive.
- R2: An event bit whose mask bit is 0 sets its status bit on the next clock edge. The bit stays set until its register is read. With visibility 0, an event whose mask bit is 1 is not recorded.
- R3: With visibility 1, masked events are recorded in the status register. They raise neither the line nor the global status bit.
- R4: A read of status register g returns its bits and clears them at the clock edge. An event arriving in the same cycle as that read remains set afterwards.
- R5: Global status bit g is 1 exactly when status register g holds a bit whose mask bit is 0. Reading the global status words clears nothing.
- R6: The line is active exactly when the global block bit is 0 and some status bit is set with its mask bit 0. It goes inactive in the cycle after the read that clears those bits, or as soon as they are masked.
- R7: Pin behaviour depends on the drive bit:
  - Push-pull: the output enable is always 1, and the pin equals the polarity bit when the line is active and its inverse when inactive.
  - Open-drain: the pin value is the same, but the output enable is 1 only while the line is active.
- R8: Writes to status registers and to the global status addresses have no effect. Writes to mask registers take effect for the line and the global status bits in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 72 | Event pulses; bits [8g+7:8g] belong to status register g |
| addr_i | input | 5 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; a status read clears at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The bench builds the block with its default 8-bit register width. With nine status registers and 8-bit words, the global summary spills into a second read word. This brings the high-half address and the padding bits of the summary within reach. The bench runs directed scenarios followed by a long random phase, comparing every cycle against a behavioural model. All four pin configurations are covered, along with reads that collide with events, and visibility switched both on and off with partial masks.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int NCHAN      = 2;
    localparam int NGRP_CH    = 3;
    localparam int NEXTRA     = 3;                    // DMA, GPI low, GPI high
    localparam int NREG       = NCHAN * NGRP_CH + NEXTRA;
    localparam int AW         = 5;
    localparam int A_MODE     = 12;
    localparam int A_GSTAT_LO = 13;
    localparam int A_GSTAT_HI = 14;
    localparam int A_MASK     = 16;
    localparam int MODE_W     = 4;
    localparam int B_GBLOCK   = 0;
    localparam int B_VIS      = 1;
    localparam int B_OD       = 2;
    localparam int B_POL      = 3;
endpackage

// File: rtl/irq_hub_group.sv
module irq_hub_group #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt_i,
    input  logic          vis_i,
    input  logic          rd_clr_i,
    input  logic          mask_we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] status_o,
    output logic [DW-1:0] mask_o,
    output logic          pend_o
);
    logic [DW-1:0] st_q, mk_q, rec;

    always_comb rec = vis_i ? evt_i : (evt_i & ~mk_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            mk_q <= '1;
        end else begin
            st_q <= (rd_clr_i ? '0 : st_q) | rec;
            if (mask_we_i) mk_q <= wdata_i;
        end
    end

    assign status_o = st_q;
    assign mask_o   = mk_q;
    assign pend_o   = |(st_q & ~mk_q);

    // R2: pending bits are not lost while the register is not read
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));

    // R2: with visibility off, a read-clear leaves no masked bit behind
    a_r2_masked_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!vis_i && rd_clr_i && !mask_we_i) |=> ((status_o & mask_o) == '0));

    // R4: an event colliding with the read survives the clear
    a_r4_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> ((status_o & $past(evt_i & ~mask_o)) == $past(evt_i & ~mask_o)));
endmodule

// File: rtl/irq_hub_regif.sv
module irq_hub_regif
    import irq_hub_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [AW-1:0]      addr_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [NREG*DW-1:0] status_i,
    input  logic [NREG*DW-1:0] mask_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [2*DW-1:0]    gstat_i,
    output logic [NREG-1:0]    rd_clr_o,
    output logic [NREG-1:0]    mask_we_o,
    output logic               mode_we_o,
    output logic [DW-1:0]      rdata_o
);
    always_comb begin
        rd_clr_o  = '0;
        mask_we_o = '0;
        mode_we_o = 1'b0;
        rdata_o   = '0;
        for (int g = 0; g < NREG; g++) begin
            if (addr_i == AW'(g)) begin
                rdata_o     = status_i[g*DW +: DW];
                rd_clr_o[g] = rd_i;
            end
            if (addr_i == AW'(A_MASK + g)) begin
                rdata_o      = mask_i[g*DW +: DW];
                mask_we_o[g] = wr_i;
            end
        end
        if (addr_i == AW'(A_MODE)) begin
            rdata_o   = DW'(mode_i);
            mode_we_o = wr_i;
        end
        if (addr_i == AW'(A_GSTAT_LO)) rdata_o = gstat_i[DW-1:0];
        if (addr_i == AW'(A_GSTAT_HI)) rdata_o = gstat_i[2*DW-1:DW];
    end
endmodule

// File: rtl/irq_hub_pin.sv
module irq_hub_pin (
    input  logic active_i,
    input  logic od_i,
    input  logic pol_i,
    output logic irq_o,
    output logic irq_oe_o
);
    always_comb begin
        irq_o    = active_i ? pol_i : ~pol_i;
        irq_oe_o = od_i ? active_i : 1'b1;
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG*DW-1:0] evt_i,
    input  logic [AW-1:0]      addr_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [DW-1:0]      wdata_i,
    output logic [DW-1:0]      rdata_o,
    output logic               irq_o,
    output logic               irq_oe_o
);
    localparam int PAD = 2 * DW - NREG;

    logic [NREG*DW-1:0] status, mask;
    logic [NREG-1:0]    pend, rd_clr, mask_we;
    logic [2*DW-1:0]    gstat;
    logic [MODE_W-1:0]  mode_q;
    logic               mode_we, active;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_grp
            irq_hub_group #(.DW(DW)) u_grp (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt_i     (evt_i[g*DW +: DW]),
                .vis_i     (mode_q[B_VIS]),
                .rd_clr_i  (rd_clr[g]),
                .mask_we_i (mask_we[g]),
                .wdata_i   (wdata_i),
                .status_o  (status[g*DW +: DW]),
                .mask_o    (mask[g*DW +: DW]),
                .pend_o    (pend[g])
            );
        end
    endgenerate

    assign gstat  = {{PAD{1'b0}}, pend};
    assign active = ~mode_q[B_GBLOCK] & (|pend);

    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_W'(1);
        else if (mode_we) mode_q <= wdata_i[MODE_W-1:0];
    end

    irq_hub_regif #(.DW(DW)) u_regif (
        .addr_i    (addr_i),
        .wr_i      (wr_i),
        .rd_i      (rd_i),
        .status_i  (status),
        .mask_i    (mask),
        .mode_i    (mode_q),
        .gstat_i   (gstat),
        .rd_clr_o  (rd_clr),
        .mask_we_o (mask_we),
        .mode_we_o (mode_we),
        .rdata_o   (rdata_o)
    );

    irq_hub_pin u_pin (
        .active_i (active),
        .od_i     (mode_q[B_OD]),
        .pol_i    (mode_q[B_POL]),
        .irq_o    (irq_o),
        .irq_oe_o (irq_oe_o)
    );

    // R6: the global block keeps the pin at its inactive level
    a_r6_block_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[B_GBLOCK] |-> (irq_o == ~mode_q[B_POL]));

    // R7: open-drain releases the pin whenever nothing is pending
    a_r7_od_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[B_OD] && pend == '0) |-> !irq_oe_o);

    // R7: push-pull always drives
    a_r7_pp_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[B_OD] |-> irq_oe_o);

    // R5: reading the summary clears nothing
    a_r5_gstat_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i && evt_i == '0 &&
         (addr_i == AW'(A_GSTAT_LO) || addr_i == AW'(A_GSTAT_HI)))
        |=> (gstat == $past(gstat)));
endmodule

// File: tb/irq_hub_tb.sv
`timescale 1ns/1ps
module irq_hub_tb;
    import irq_hub_pkg::*;
    localparam int DW = 8;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NREG*DW-1:0] evt;
    logic [AW-1:0]      addr;
    logic               wr, rd;
    logic [DW-1:0]      wdata, rdata;
    logic               irq, irq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural model state
    logic [7:0] m_st [NREG];
    logic [7:0] m_mk [NREG];
    logic [3:0] m_mode;

    always #4 clk = ~clk;

    irq_hub #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .addr_i(addr), .wr_i(wr),
        .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .irq_oe_o(irq_oe)
    );

    function automatic logic [15:0] m_gstat();
        logic [15:0] r = '0;
        for (int g = 0; g < NREG; g++) r[g] = |(m_st[g] & ~m_mk[g]);
        return r;
    endfunction

    function automatic logic m_active();
        return !m_mode[0] && (m_gstat() != 0);
    endfunction

    function automatic logic [7:0] m_rdata(input int a);
        logic [15:0] gs = m_gstat();
        if (a < NREG) return m_st[a];
        if (a >= A_MASK && a < A_MASK + NREG) return m_mk[a - A_MASK];
        if (a == A_MODE) return {4'b0, m_mode};
        if (a == A_GSTAT_LO) return gs[7:0];
        if (a == A_GSTAT_HI) return gs[15:8];
        return 8'h00;
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int g = 0; g < NREG; g++) begin
            m_st[g] = 8'h00;
            m_mk[g] = 8'hFF;
        end
        m_mode = 4'h1;
    endtask

    // one cycle: drive, compare combinational outputs, update model at the edge
    task automatic step(input string req, input int a, input bit r, input bit w,
                        input logic [7:0] wd, input logic [NREG*DW-1:0] e);
        logic [7:0] rec;
        logic act;
        addr = AW'(a); rd = r; wr = w; wdata = wd; evt = e;
        #1;
        act = m_active();
        chk(req, "rdata", rdata, m_rdata(a));
        chk("R6", "active pin", {7'b0, irq}, {7'b0, act ? m_mode[3] : ~m_mode[3]});
        chk("R7", "output enable", {7'b0, irq_oe}, {7'b0, m_mode[2] ? act : 1'b1});
        @(posedge clk);
        for (int g = 0; g < NREG; g++) begin
            rec = m_mode[1] ? e[g*8 +: 8] : (e[g*8 +: 8] & ~m_mk[g]);
            m_st[g] = ((r && a == g) ? 8'h00 : m_st[g]) | rec;
        end
        if (w && a >= A_MASK && a < A_MASK + NREG) m_mk[a - A_MASK] = wd;
        if (w && a == A_MODE) m_mode = wd[3:0];
        @(negedge clk);
    endtask

    function automatic logic [NREG*DW-1:0] ev(input int g, input logic [7:0] v);
        logic [NREG*DW-1:0] x = '0;
        x[g*8 +: 8] = v;
        return x;
    endfunction

    initial begin
        rst_n = 1'b0; evt = '0; addr = '0; wr = 0; rd = 0; wdata = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int g = 0; g < NREG; g++) step("R1", g, 0, 0, 0, '0);
        step("R1", A_MASK + 4, 0, 0, 0, '0);
        step("R1", A_MODE, 0, 0, 0, '0);
        chk("R1", "mode reset", rdata, 8'h01);
        chk("R1", "pin inactive", {7'b0, irq}, 8'h01);

        // R2: masked event dropped with visibility off
        step("R2", 0, 0, 0, 0, ev(0, 8'h5A));
        step("R2", 0, 0, 0, 0, '0);
        chk("R2", "masked not stored", rdata, 8'h00);

        // R2/R6: unmask, open the global block, fire an event
        step("R2", A_MASK + 0, 0, 1, 8'h00, '0);
        step("R6", A_MODE, 0, 1, 8'h00, '0);
        step("R2", 0, 0, 0, 0, ev(0, 8'h08));
        step("R5", A_GSTAT_LO, 0, 0, 0, '0);
        chk("R5", "gstat bit0", rdata, 8'h01);
        chk("R6", "line active-low", {7'b0, irq}, 8'h00);
        step("R5", A_GSTAT_LO, 1, 0, 0, '0);   // reading summary clears nothing
        step("R4", 0, 1, 0, 0, '0);              // read-clear status 0
        step("R6", 0, 0, 0, 0, '0);
        chk("R4", "cleared", rdata, 8'h00);
        chk("R6", "line dropped", {7'b0, irq}, 8'h01);

        // R4: event colliding with a read survives
        step("R4", 0, 0, 0, 0, ev(0, 8'h01));
        step("R4", 0, 1, 0, 0, ev(0, 8'h80));
        step("R4", 0, 0, 0, 0, '0);
        chk("R4", "collision kept", rdata, 8'h80);
        step("R4", 0, 1, 0, 0, '0);

        // R3: visibility on with partial mask
        step("R3", A_MODE, 0, 1, 8'h02, '0);
        step("R3", A_MASK + 4, 0, 1, 8'hF0, '0);
        step("R3", 4, 0, 0, 0, ev(4, 8'hF0));
        step("R3", 4, 0, 0, 0, '0);
        chk("R3", "masked recorded", rdata, 8'hF0);
        chk("R3", "line quiet", {7'b0, irq}, 8'h01);
        step("R3", 4, 1, 0, 0, ev(4, 8'h03));
        step("R3", A_GSTAT_LO, 0, 0, 0, '0);
        chk("R3", "gstat bit4", rdata, 8'h10);
        step("R3", 4, 1, 0, 0, '0);

        // R5: summary high word (register 8)
        step("R5", A_MASK + 8, 0, 1, 8'h00, '0);
        step("R5", 8, 0, 0, 0, ev(8, 8'h40));
        step("R5", A_GSTAT_HI, 0, 0, 0, '0);
        chk("R5", "gstat high", rdata, 8'h01);

        // R8: writes to status and summary ignored; masking drops line
        step("R8", 8, 0, 1, 8'h00, '0);
        step("R8", A_GSTAT_HI, 0, 1, 8'h00, '0);
        step("R8", 8, 0, 0, 0, '0);
        chk("R8", "status write ignored", rdata, 8'h40);
        step("R8", A_MASK + 8, 0, 1, 8'h40, '0);
        step("R8", A_GSTAT_HI, 0, 0, 0, '0);
        chk("R8", "mask drops summary", rdata, 8'h00);
        step("R8", A_MASK + 8, 0, 1, 8'h00, '0);

        // R7: all four pin configurations, active then blocked
        for (int c = 0; c < 4; c++) begin
            step("R7", A_MODE, 0, 1, 8'(c << 2), '0);
            step("R7", A_MODE, 0, 0, 0, '0);
            step("R7", A_MODE, 0, 1, 8'((c << 2) | 1), '0);
            step("R7", A_MODE, 0, 0, 0, '0);
        end
        step("R7", 8, 1, 0, 0, '0);

        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            int a = $urandom_range(0, 31);
            bit r = ($urandom_range(0, 2) == 0);
            bit w = ($urandom_range(0, 5) == 0);
            logic [7:0] wd = 8'($urandom);
            logic [NREG*DW-1:0] e = '0;
            if (a == A_MODE) wd = wd & 8'h0E;
            for (int g = 0; g < NREG; g++)
                if ($urandom_range(0, 7) == 0) e[g*8 +: 8] = 8'(1 << $urandom_range(0, 7));
            step("R2", a, r, w, wd, e);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule